// File: doc/BRIEF.md
# Data-Availability-Gated DMA Burst Sequencer

This block sits between a host that asks for a block of data to be moved and a bus master core that moves it. The host gives only a total Dword count and a start destination address; it does not know how much of that data has already arrived in the local SRAM FIFO. The sequencer watches the FIFO fill level and cuts the total into bursts. It hands the bus core a burst only when every Dword of that burst is already stored, so the core never runs dry in the middle of a transfer.

Each burst length is the smallest of three values: the Dwords still owed, the Dwords currently buffered, and a parameter cap. That value is then rounded down to an even count, so every transfer stays on a 64-bit boundary. After the core reports a burst complete, the sequencer advances the destination address and the remaining count. It keeps going until the whole total has been delivered, then raises a done flag that stays high until the next request. A request for zero Dwords or for an odd number of Dwords is refused with an error flag.

Top module: `dma_burst_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `burst_start` are all 0.
- R2: No burst is started while fewer than 2 Dwords are buffered. A started burst never needs more Dwords than `fill_count` showed in the cycle before `burst_start`.
- R3: Each burst length equals min(remaining, fill_count, MAX_BURST) with bit 0 cleared, so it is always even and non-zero.
- R4: `burst_addr` of each burst equals the request start address plus 4 times the Dwords completed so far in that request.
- R5: Bursts are issued until their lengths sum exactly to the requested total. Then `busy` goes to 0 and `done` goes to 1.
- R6: A request whose length is zero or has bit 0 set raises `err`, issues no burst and leaves `busy` at 0.
- R7: `done` stays at 1 until the next `req_valid` accepted in idle. That request clears both `done` and `err`.
- R8: `req_valid` while `busy` is 1 has no effect on the running transfer.
- R9: `burst_start` is a single-cycle pulse. No further burst starts before `burst_done` is seen for the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only in idle |
| req_len | input | LEN_W | Total Dwords to move |
| req_addr | input | ADDR_W | Destination byte address of the first Dword |
| fill_count | input | FILL_W | Dwords currently stored in the FIFO |
| burst_done | input | 1 | Bus core reports the current burst complete |
| burst_start | output | 1 | One-cycle launch strobe for the bus core |
| burst_len | output | LEN_W | Dword count of the burst being launched |
| burst_addr | output | ADDR_W | Destination byte address of the burst |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last request completed, held until next request |
| err | output | 1 | Last request refused (zero or odd length) |

## Verification
A table of requests covers four cases, each separating a different limit on burst size:
- an ample buffer with a short total, where the remaining count limits;
- an ample buffer with a long total, where the cap limits;
- an odd fill level, which tests rounding down to even;
- the minimum two-Dword transfer.

Directed tests then cover three further cases. A starved buffer shows that nothing launches until data exists. A fill level rising during a request shows bursts growing with availability. A request injected mid-transfer shows that it is ignored. Zero and odd lengths check the refusal path and the clearing of the held flags.

// File: rtl/dma_seq_pkg.sv
// Package: shared state encoding for the burst sequencer.
// Assumes: imported by every sequencer module.
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_DATA = 3'd1,
        ST_LAUNCH    = 3'd2,
        ST_WAIT_DONE = 3'd3,
        ST_FINISH    = 3'd4
    } seq_state_t;
endpackage

// File: rtl/dma_seq_len_calc.sv
// Module: combinational burst-size selector.
// Picks min(remaining, fill, cap) and clears bit 0, so the result is even.
// Assumes: MAX_BURST is even and at least 2.
module dma_seq_len_calc #(
    parameter int LEN_W     = 16,
    parameter int FILL_W    = 16,
    parameter int MAX_BURST = 16
) (
    input  logic [LEN_W-1:0]  remaining,
    input  logic [FILL_W-1:0] fill,
    output logic [LEN_W-1:0]  cand,
    output logic              cand_nz
);
    localparam int CMP_W = (LEN_W > FILL_W) ? LEN_W : FILL_W;

    logic [CMP_W-1:0] rem_x, fill_x, cap_x, min_rf, min_all;

    // Purpose: three-way minimum, then even rounding.
    always_comb begin
        rem_x   = CMP_W'(remaining);
        fill_x  = CMP_W'(fill);
        cap_x   = CMP_W'(MAX_BURST);
        min_rf  = (rem_x < fill_x) ? rem_x : fill_x;
        min_all = (min_rf < cap_x) ? min_rf : cap_x;
        cand    = LEN_W'(min_all) & ~LEN_W'(1);
        cand_nz = (cand != '0);
    end
endmodule

// File: rtl/dma_seq_bookkeep.sv
// Module: remaining-count, destination-address and burst-length registers.
// Assumes: control strobes from the FSM are mutually exclusive; LEN_W+2 <= ADDR_W.
module dma_seq_bookkeep #(
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int MAX_BURST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              load_len,
    input  logic              advance,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  cand,
    output logic [LEN_W-1:0]  remaining,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  blen,
    output logic              last
);
    logic [LEN_W-1:0]  rem_q, blen_q;
    logic [ADDR_W-1:0] addr_q;

    // Purpose: latch request, capture burst size, step counters on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            addr_q <= '0;
            blen_q <= '0;
        end else begin
            if (load_req) begin
                rem_q  <= req_len;
                addr_q <= req_addr;
            end
            if (load_len) begin
                blen_q <= cand;
            end
            if (advance) begin
                rem_q  <= rem_q - blen_q;
                addr_q <= addr_q + ADDR_W'({blen_q, 2'b00});
            end
        end
    end

    assign remaining = rem_q;
    assign addr      = addr_q;
    assign blen      = blen_q;
    assign last      = (rem_q == blen_q);

    // R3: a captured burst is even, non-zero and within the cap
    a_r3_len_even: assert property (@(posedge clk) disable iff (!rst_n)
        load_len |=> (blen_q[0] == 1'b0 && blen_q != '0 && blen_q <= LEN_W'(MAX_BURST)));
    // R5: a burst never exceeds what is still owed
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        load_len |=> (blen_q <= rem_q));
endmodule

// File: rtl/dma_seq_fsm.sv
// Module: sequencing state machine with held done/error flags.
// Assumes: burst_done arrives only while a burst is outstanding; others are ignored.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cand_nz,
    input  logic             burst_done,
    input  logic             last,
    output logic             load_req,
    output logic             load_len,
    output logic             advance,
    output logic             burst_start,
    output logic             busy,
    output logic             done,
    output logic             err
);
    seq_state_t state_q, state_d;
    logic       req_ok, done_q, err_q;

    assign req_ok = (req_len != '0) && !req_len[0];

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid && req_ok) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA: if (cand_nz) state_d = ST_LAUNCH;
            ST_LAUNCH:    state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (burst_done) state_d = last ? ST_FINISH : ST_WAIT_DATA;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: held completion and refusal flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            done_q <= 1'b0;
            err_q  <= !req_ok;
        end else if (state_q == ST_FINISH) begin
            done_q <= 1'b1;
        end
    end

    assign load_req    = (state_q == ST_IDLE) && req_valid && req_ok;
    assign load_len    = (state_q == ST_WAIT_DATA) && cand_nz;
    assign advance     = (state_q == ST_WAIT_DONE) && burst_done;
    assign burst_start = (state_q == ST_LAUNCH);
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign err         = err_q;

    // R9: launch strobe lasts one cycle
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);
    // R7: done is only shown while idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
    // R6: a refused request never leaves the block busy
    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !busy);
    // R8: a request seen mid-transfer does not reset the flags
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !err_q);
endmodule

// File: rtl/dma_burst_sequencer.sv
// Module: top of the data-availability-gated DMA burst sequencer.
// Splits a host total into even bursts that are fully backed by buffered data.
// Assumes: fill_count counts Dwords already stored; the bus core pulses burst_done once per burst.
module dma_burst_sequencer #(
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int FILL_W    = 16,
    parameter int MAX_BURST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FILL_W-1:0] fill_count,
    input  logic              burst_done,
    output logic              burst_start,
    output logic [LEN_W-1:0]  burst_len,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CMP_W = (LEN_W > FILL_W) ? LEN_W : FILL_W;

    logic [LEN_W-1:0] remaining, cand;
    logic             cand_nz, last, load_req, load_len, advance;

    dma_seq_len_calc #(.LEN_W(LEN_W), .FILL_W(FILL_W), .MAX_BURST(MAX_BURST)) u_calc (
        .remaining (remaining),
        .fill      (fill_count),
        .cand      (cand),
        .cand_nz   (cand_nz)
    );

    dma_seq_bookkeep #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_book (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .load_len  (load_len),
        .advance   (advance),
        .req_len   (req_len),
        .req_addr  (req_addr),
        .cand      (cand),
        .remaining (remaining),
        .addr      (burst_addr),
        .blen      (burst_len),
        .last      (last)
    );

    dma_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_len     (req_len),
        .cand_nz     (cand_nz),
        .burst_done  (burst_done),
        .last        (last),
        .load_req    (load_req),
        .load_len    (load_len),
        .advance     (advance),
        .burst_start (burst_start),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    // R2: every launched burst was covered by buffered data when it was sized
    a_r2_backed: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> (CMP_W'(burst_len) <= CMP_W'($past(fill_count))));
endmodule

// File: tb/dma_burst_sequencer_tb.sv
module dma_burst_sequencer_tb;
    localparam int LEN_W = 16, ADDR_W = 32, FILL_W = 16, MAX_B = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [FILL_W-1:0] fill_count = '0;
    logic              burst_done = 1'b0;
    logic              burst_start, busy, done, err;
    logic [LEN_W-1:0]  burst_len;
    logic [ADDR_W-1:0] burst_addr;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_burst_sequencer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .FILL_W(FILL_W), .MAX_BURST(MAX_B)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_addr(req_addr), .fill_count(fill_count), .burst_done(burst_done),
        .burst_start(burst_start), .burst_len(burst_len), .burst_addr(burst_addr),
        .busy(busy), .done(done), .err(err)
    );

    // Request table: total, start address, constant fill level
    localparam int NV = 4;
    localparam int V_LEN  [NV] = '{8, 40, 20, 2};
    localparam int V_ADDR [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
    localparam int V_FILL [NV] = '{100, 100, 7, 2};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_req(input int len, input int addr);
        @(negedge clk);
        req_valid = 1'b1; req_len = LEN_W'(len); req_addr = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            if (burst_start) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic finish_burst();
        @(negedge clk); @(negedge clk);
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
    endtask

    task automatic serve(input int exp_len, input int exp_addr);
        bit seen;
        wait_start(seen);
        check(seen, "R5 burst expected", seen, 1);
        check(burst_len == LEN_W'(exp_len), "R3 burst length", burst_len, exp_len);
        check(burst_addr == ADDR_W'(exp_addr), "R4 burst address", burst_addr, exp_addr);
        @(negedge clk);
        check(!burst_start, "R9 start pulse width", burst_start, 0);
        finish_burst();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    function automatic int min3(input int a, input int b, input int c);
        int m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err && !burst_start, "R1 reset outputs",
              {busy, done, err, burst_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err, "R1 after release", {busy, done, err}, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int rem, sent, b;
            fill_count = FILL_W'(V_FILL[v]);
            send_req(V_LEN[v], V_ADDR[v]);
            rem = V_LEN[v]; sent = 0;
            while (rem > 0) begin
                b = min3(rem, V_FILL[v], MAX_B) & ~1;
                serve(b, V_ADDR[v] + 4 * sent);
                rem -= b; sent += b;
            end
            wait_idle();
            @(negedge clk);
            check(!busy && done && !err, "R5 completion flags", {busy, done, err}, 3'b010);
        end

        // R7 done holds while idle
        repeat (10) @(negedge clk);
        check(done, "R7 done held", done, 1);

        // R6 odd length refused; R7 done cleared by the request
        fill_count = 100;
        send_req(5, 32'h5000);
        check(err && !done && !busy, "R6 odd refused", {err, done, busy}, 3'b100);
        begin
            bit seen;
            wait_start(seen);
            check(!seen && !busy, "R6 no burst after odd", seen, 0);
        end
        // R6 zero length refused
        send_req(0, 32'h5000);
        check(err && !busy, "R6 zero refused", {err, busy}, 2'b10);
        // R7 a valid request clears err
        send_req(2, 32'h5100);
        check(!err && busy, "R7 err cleared", {err, busy}, 2'b01);
        serve(2, 32'h5100);
        wait_idle();

        // R2 starvation: nothing starts below two buffered Dwords
        fill_count = 0;
        send_req(10, 32'h6000);
        begin
            int starts = 0;
            for (int i = 0; i < 20; i++) begin
                if (burst_start) starts++;
                @(negedge clk);
            end
            check(starts == 0 && busy, "R2 starved no start", starts, 0);
            fill_count = 1;
            for (int i = 0; i < 10; i++) begin
                if (burst_start) starts++;
                @(negedge clk);
            end
            check(starts == 0, "R2 one Dword no start", starts, 0);
        end
        fill_count = 5;
        serve(4, 32'h6000);
        fill_count = 100;
        serve(6, 32'h6010);
        wait_idle();
        @(negedge clk);
        check(done && !busy, "R5 done after growing fill", {done, busy}, 2'b10);

        // R8 request while busy is ignored
        fill_count = 2;
        send_req(4, 32'h7000);
        begin
            bit seen;
            wait_start(seen);
            check(burst_addr == 32'h7000, "R8 first burst addr", burst_addr, 32'h7000);
            @(negedge clk);
            req_valid = 1'b1; req_len = 30; req_addr = 32'h9000;
            @(negedge clk);
            req_valid = 1'b0;
            check(busy && !err, "R8 busy unaffected", {busy, err}, 2'b10);
            finish_burst();
        end
        serve(2, 32'h7008);
        wait_idle();
        @(negedge clk);
        check(done && !busy, "R8 total unchanged, done", {done, busy}, 2'b10);

        // R1 reset mid-transfer returns to idle
        fill_count = 0;
        send_req(8, 32'h8000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done && !err, "R1 reset mid-run", {busy, done, err}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule